// File: doc/BRIEF.md
# Coprocessor Transfer Handshake Sequencer

This block sits on the coprocessor side of a processor-to-coprocessor link. Each time the processor offers an instruction to the coprocessor's execute stage, the block answers with a 2-bit handshake code. The code says one of four things: the coprocessor is not present, it must wait, it is ready to go, or the next transfer is the last one.

For memory load and store instructions, the block counts down the words still to move. It reports the end of the burst one cycle early. The last-transfer code therefore appears while one word is still outstanding. Busy cycles insert wait codes and consume no words.

The block also produces two further outputs. One is a commit strobe, gated by the condition-pass input captured at entry. The other is an enable for the coprocessor's data-out bus. Its ownership window runs from the cycle after an instruction enters execute until the next instruction enters, and late cancellation or a failed condition does not change it. The block runs on the free-running clock, so it keeps advancing through busy cycles while the processor pipeline is stalled.

Top module: `cp_xfer_seq`

## Requirements
- R1: Handshake codes are 2'b00 wait, 2'b01 go, 2'b10 absent and 2'b11 last. With no instruction in progress, the output rests at wait (00).
- R2: When an entry strobe arrives with `cp_here` low, the next cycle shows absent (10) for exactly one cycle, then wait. `dout_en` is low from the cycle after that entry.
- R3: A load (class 3'd3) or store (class 3'd4) of N ≥ 2 words shows go in N−1 non-busy cycles, then last in the next non-busy cycle, then wait.
- R4: A load or store of one word shows only wait codes and then last, with no go. A word count of 0 is treated as 1.
- R5: While `busy` is high during an active sequence, the code is wait and no word is consumed.
- R6: Any other class (3'd0 internal op, 3'd1 register read, 3'd2 register write, 3'd5 to 3'd7) shows wait while busy, then a single go, then returns to wait.
- R7: `pass` is captured with the entry strobe. `commit` pulses in the cycle of the final code (last for a transfer, go for another class) only if the captured `pass` was high. With `pass` low the handshake is identical but `commit` stays low.
- R8: `late_cancel` high during an active sequence, without a new entry, returns the block to idle on the next cycle. No commit follows, and the word counter is cleared, so the next instruction starts from its own count.
- R9: `dout_en` rises in the cycle after the entry of a register read (3'd1) or store (3'd4) with `cp_here` high. It stays high until the clock edge of the next entry, and it is low for every other class.
- R10: Late cancellation and a low `pass` leave `dout_en` unchanged.
- R11: A synchronous reset `rst` returns the block to idle: code wait, `dout_en` low and `commit` low.
- R12: An entry strobe arriving during an active sequence abandons that sequence and starts the new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_vld | input | 1 | Instruction enters the execute stage this cycle |
| instr_cls | input | 3 | Decoded instruction class |
| word_cnt | input | CNT_W | Number of words for a load or store |
| cp_here | input | 1 | Instruction targets this coprocessor |
| busy | input | 1 | Coprocessor cannot proceed this cycle |
| pass | input | 1 | Condition of the entering instruction is true |
| late_cancel | input | 1 | Abort the instruction in progress |
| hs_code | output | 2 | Handshake response code |
| dout_en | output | 1 | Coprocessor owns the data-out bus |
| commit | output | 1 | Coprocessor state update strobe |

## Verification
The bench builds the block with `CNT_W` = 3, so the largest burst is seven words. A full-scale seven-word load can be walked from its first go down to its last code. The narrow counter also puts the zero-count clamp and the single-word case right next to the top of the range. At this width, a counter that wraps or decrements past one produces a visibly wrong code within a few cycles.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    typedef enum logic [1:0] {
        HS_WAIT   = 2'b00,
        HS_GO     = 2'b01,
        HS_ABSENT = 2'b10,
        HS_LAST   = 2'b11
    } hs_e;

    typedef enum logic [2:0] {
        CLS_INTOP = 3'd0,
        CLS_RDREG = 3'd1,
        CLS_WRREG = 3'd2,
        CLS_LOAD  = 3'd3,
        CLS_STORE = 3'd4
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ABSENT,
        ST_OP,
        ST_XFER
    } st_e;

    function automatic logic is_xfer(input logic [2:0] cls);
        return (cls == CLS_LOAD) || (cls == CLS_STORE);
    endfunction

    function automatic logic drives_bus(input logic [2:0] cls);
        return (cls == CLS_RDREG) || (cls == CLS_STORE);
    endfunction

endpackage

// File: rtl/cpx_resp_enc.sv
module cpx_resp_enc
    import cpx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  st_e              st,
    input  logic [CNT_W-1:0] rem,
    input  logic             busy,
    output hs_e              hs,
    output logic             fin,
    output logic             take
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        hs   = HS_WAIT;
        fin  = 1'b0;
        take = 1'b0;
        case (st)
            ST_ABSENT: hs = HS_ABSENT;
            ST_OP: begin
                if (!busy) begin
                    hs  = HS_GO;
                    fin = 1'b1;
                end
            end
            ST_XFER: begin
                if (!busy) begin
                    if (rem > ONE) begin
                        hs   = HS_GO;
                        take = 1'b1;
                    end else begin
                        hs  = HS_LAST;
                        fin = 1'b1;
                    end
                end
            end
            default: hs = HS_WAIT;
        endcase
    end

endmodule

// File: rtl/cpx_word_ctr.sv
module cpx_word_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             clr,
    output logic [CNT_W-1:0] rem
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load) begin
            rem_d = (load_val == ZERO) ? ONE : load_val;
        end else if (clr) begin
            rem_d = ZERO;
        end else if (dec) begin
            rem_d = rem_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rem_q <= ZERO;
        else     rem_q <= rem_d;
    end

    assign rem = rem_q;

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |=> rem_q != ZERO); // R4

    AST_DEC_ABOVE_ONE: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && !clr) |-> rem_q > ONE); // R3

endmodule

// File: rtl/cpx_bus_own.sv
module cpx_bus_own
    import cpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       instr_vld,
    input  logic [2:0] instr_cls,
    input  logic       cp_here,
    output logic       own
);

    logic own_d, own_q;

    always_comb begin
        own_d = own_q;
        if (instr_vld) own_d = cp_here && drives_bus(instr_cls);
    end

    always_ff @(posedge clk) begin
        if (rst) own_q <= 1'b0;
        else     own_q <= own_d;
    end

    assign own = own_q;

    AST_OWN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !instr_vld |=> $stable(own_q)); // R9

endmodule

// File: rtl/cp_xfer_seq.sv
module cp_xfer_seq
    import cpx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_vld,
    input  logic [2:0]       instr_cls,
    input  logic [CNT_W-1:0] word_cnt,
    input  logic             cp_here,
    input  logic             busy,
    input  logic             pass,
    input  logic             late_cancel,
    output logic [1:0]       hs_code,
    output logic             dout_en,
    output logic             commit
);

    typedef struct packed {
        st_e  st;
        logic pass;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [CNT_W-1:0] rem;
    hs_e              hs;
    logic             fin, take;
    logic             ctr_load, ctr_dec, ctr_clr;

    cpx_resp_enc #(.CNT_W(CNT_W)) u_enc (
        .st   (seq_q.st),
        .rem  (rem),
        .busy (busy),
        .hs   (hs),
        .fin  (fin),
        .take (take)
    );

    cpx_word_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (word_cnt),
        .dec      (ctr_dec),
        .clr      (ctr_clr),
        .rem      (rem)
    );

    cpx_bus_own u_own (
        .clk       (clk),
        .rst       (rst),
        .instr_vld (instr_vld),
        .instr_cls (instr_cls),
        .cp_here   (cp_here),
        .own       (dout_en)
    );

    always_comb begin
        seq_d    = seq_q;
        ctr_load = instr_vld && cp_here && is_xfer(instr_cls);
        ctr_dec  = take && !late_cancel && !instr_vld;
        ctr_clr  = !instr_vld && (late_cancel || fin);
        if (instr_vld) begin
            seq_d.pass = pass;
            if (!cp_here)                seq_d.st = ST_ABSENT;
            else if (is_xfer(instr_cls)) seq_d.st = ST_XFER;
            else                         seq_d.st = ST_OP;
        end else if (late_cancel) begin
            seq_d.st = ST_IDLE;
        end else begin
            case (seq_q.st)
                ST_ABSENT:     seq_d.st = ST_IDLE;
                ST_OP, ST_XFER: if (fin) seq_d.st = ST_IDLE;
                default:       seq_d.st = seq_q.st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.st   <= ST_IDLE;
            seq_q.pass <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign hs_code = hs;
    assign commit  = fin && seq_q.pass && !late_cancel;

    AST_ABSENT_CODE: assert property (@(posedge clk) disable iff (rst)
        (instr_vld && !cp_here) |=> hs_code == HS_ABSENT); // R2

    AST_ABSENT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (instr_vld && !cp_here) |=> !dout_en); // R2

    AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (late_cancel && !instr_vld) |=> (hs_code == HS_WAIT && !commit)); // R8

    AST_CANCEL_KEEPS_BUS: assert property (@(posedge clk) disable iff (rst)
        (late_cancel && !instr_vld) |=> $stable(dout_en)); // R10

    AST_BUSY_WAIT: assert property (@(posedge clk) disable iff (rst)
        (busy && (seq_q.st == ST_OP || seq_q.st == ST_XFER)) |-> hs_code == HS_WAIT); // R5

    AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (hs_code == HS_LAST && !instr_vld) |=> hs_code == HS_WAIT); // R3

    AST_COMMIT_FINAL: assert property (@(posedge clk) disable iff (rst)
        commit |-> (hs_code == HS_LAST || hs_code == HS_GO)); // R7

endmodule

// File: tb/sim_cp_xfer_seq.sv
module sim_cp_xfer_seq;

    localparam int CNT_W = 3;
    localparam int NV    = 45;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             instr_vld = 1'b0;
    logic [2:0]       instr_cls = 3'd0;
    logic [CNT_W-1:0] word_cnt = '0;
    logic             cp_here = 1'b1;
    logic             busy = 1'b0;
    logic             pass = 1'b0;
    logic             late_cancel = 1'b0;
    logic [1:0]       hs_code;
    logic             dout_en;
    logic             commit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cp_xfer_seq #(.CNT_W(CNT_W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .instr_vld   (instr_vld),
        .instr_cls   (instr_cls),
        .word_cnt    (word_cnt),
        .cp_here     (cp_here),
        .busy        (busy),
        .pass        (pass),
        .late_cancel (late_cancel),
        .hs_code     (hs_code),
        .dout_en     (dout_en),
        .commit      (commit)
    );

    // row: vld, cls, cnt, here, busy, pass, lc | exp hs, exp en, exp cm | req
    localparam logic [18:0] VEC [NV] = '{
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b0, 4'd1},  // R1 idle
        {1'b1,3'd3,3'd3,1'b1,1'b0,1'b1,1'b0, 2'b00,1'b0,1'b0, 4'd1},  // R1 load 3 enters
        {1'b0,3'd0,3'd0,1'b1,1'b1,1'b0,1'b0, 2'b00,1'b0,1'b0, 4'd5},  // R5 busy wait
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0, 4'd3},  // R3 go
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0, 4'd3},  // R3 go
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b11,1'b0,1'b1, 4'd3},  // R3 last + commit
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b0, 4'd3},  // R3 back to wait
        {1'b1,3'd4,3'd1,1'b1,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b0, 4'd4},  // R4 store 1, pass low
        {1'b0,3'd0,3'd0,1'b1,1'b1,1'b0,1'b0, 2'b00,1'b1,1'b0, 4'd9},  // R9 bus owned
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b11,1'b1,1'b0, 4'd7},  // R7 last, no commit
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b00,1'b1,1'b0, 4'd9},  // R9 held after end
        {1'b1,3'd1,3'd0,1'b0,1'b0,1'b1,1'b0, 2'b00,1'b1,1'b0, 4'd9},  // R9 until next entry
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b10,1'b0,1'b0, 4'd2},  // R2 absent
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b0, 4'd2},  // R2 one cycle only
        {1'b1,3'd1,3'd0,1'b1,1'b0,1'b1,1'b0, 2'b00,1'b0,1'b0, 4'd6},  // R6 register read
        {1'b0,3'd0,3'd0,1'b1,1'b1,1'b0,1'b0, 2'b00,1'b1,1'b0, 4'd6},  // R6 busy
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b1,1'b1, 4'd6},  // R6 single go
        {1'b1,3'd3,3'd5,1'b1,1'b0,1'b1,1'b0, 2'b00,1'b1,1'b0, 4'd8},  // R8 load 5
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0, 4'd9},  // R9 load drops bus
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b1, 2'b01,1'b0,1'b0, 4'd8},  // R8 cancel
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b0, 4'd8},  // R8 idle
        {1'b1,3'd3,3'd2,1'b1,1'b0,1'b1,1'b0, 2'b00,1'b0,1'b0, 4'd8},  // R8 fresh load 2
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0, 4'd8},  // R8 go
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b11,1'b0,1'b1, 4'd8},  // R8 last
        {1'b1,3'd4,3'd0,1'b1,1'b0,1'b1,1'b0, 2'b00,1'b0,1'b0, 4'd4},  // R4 count 0
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b11,1'b1,1'b1, 4'd4},  // R4 treated as 1
        {1'b1,3'd4,3'd7,1'b1,1'b0,1'b1,1'b0, 2'b00,1'b1,1'b0, 4'd12}, // R12 store 7
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b1,1'b0, 4'd12}, // R12 go
        {1'b0,3'd0,3'd0,1'b1,1'b1,1'b0,1'b0, 2'b00,1'b1,1'b0, 4'd5},  // R5 mid-burst busy
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b1,1'b0, 4'd5},  // R5 go
        {1'b1,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b1,1'b0, 4'd12}, // R12 new entry
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0, 4'd12}, // R12 internal op go
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b0, 4'd12}, // R12 idle
        {1'b1,3'd4,3'd4,1'b1,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b0, 4'd10}, // R10 store, pass low
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b1, 2'b01,1'b1,1'b0, 4'd10}, // R10 cancel
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b00,1'b1,1'b0, 4'd10}, // R10 bus kept
        {1'b1,3'd3,3'd7,1'b1,1'b0,1'b1,1'b0, 2'b00,1'b1,1'b0, 4'd3},  // R3 full scale
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0, 4'd3},  // R3
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0, 4'd3},  // R3
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0, 4'd3},  // R3
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0, 4'd3},  // R3
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0, 4'd3},  // R3
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0, 4'd3},  // R3 sixth go
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b11,1'b0,1'b1, 4'd3},  // R3 last
        {1'b0,3'd0,3'd0,1'b1,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b0, 4'd1}   // R1 rest
    };

    task automatic check(input int req, input logic [1:0] e_hs,
                         input logic e_en, input logic e_cm);
        n_chk++;
        if (hs_code !== e_hs || dout_en !== e_en || commit !== e_cm) begin
            n_fail++;
            $display("FAIL R%0d hs/en/cm actual=%b/%b/%b expected=%b/%b/%b",
                     req, hs_code, dout_en, commit, e_hs, e_en, e_cm);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(11, 2'b00, 1'b0, 1'b0); // R11 reset state
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {instr_vld, instr_cls, word_cnt, cp_here, busy, pass, late_cancel} = VEC[i][18:8];
            #1;
            check(int'(VEC[i][3:0]), VEC[i][7:6], VEC[i][5], VEC[i][4]);
        end
        // R11: reset in the middle of a store burst
        @(negedge clk);
        {instr_vld, instr_cls, word_cnt, cp_here, busy, pass, late_cancel} =
            {1'b1, 3'd4, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0};
        @(negedge clk);
        instr_vld = 1'b0;
        #1;
        check(11, 2'b01, 1'b1, 1'b0); // R11 burst under way
        rst = 1'b1;
        @(negedge clk);
        #1;
        check(11, 2'b00, 1'b0, 1'b0); // R11 cleared by reset
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(11, 2'b00, 1'b0, 1'b0); // R11 stays idle after release
        finish_run();
    end

endmodule